// File: doc/BRIEF.md
# Page-Mapping Flash Translation Unit

This block turns logical page reads and writes into accesses on a flash array organised as erase blocks of pages. It keeps a table that maps each logical page to a physical page. A write never overwrites data in place. It programs the next erased page of the currently open block, points the table entry at that page, and marks the page that held the previous copy as invalid.

Every physical page carries a state: erased, valid or invalid. The array refuses a program to any page that is not erased. A block is erased only once every one of its pages is invalid, and its erase count then goes up by one. When the open block runs out of erased pages, the unit opens the fully erased block with the fewest erases. This spreads wear over the array. Valid pages are never copied, so the array can fill with blocks that are partly valid. Once that happens, writes are refused.

Requests use a valid/ready handshake. Each accepted request gets exactly one response, one cycle later. After every write the unit is busy for a few cycles while it erases blocks and opens a new one.

Top module: `ftl_mapper`

## Requirements
- R1: After reset the unit is ready, shows no response, and every logical page reads as unmapped. Physical block 0 is open, with page 0 as its next page.
- R2: A read of a logical page with no mapping returns all-ones data with the unmapped flag set and the error flag clear.
- R3: An accepted write programs the next erased page of the open block. Pages are taken in ascending order, and the response reports the physical page number as block × pages-per-block + page.
- R4: A write to a logical page that is already mapped goes to a new physical page. Later reads of that logical page return the newest data.
- R5: A program aimed at a page that is not erased is refused. The response sets the error flag, and the mapping and stored data stay unchanged.
- R6: A block is erased only when all of its pages are invalid, and each erase adds one to that block's erase count. Valid data in a block that is only partly invalid stays readable.
- R7: When the open block has no erased page left, the new open block is the fully erased block with the lowest erase count. Ties go to the lowest block index. If no block is fully erased, the full block stays open.
- R8: A response arrives in the cycle after acceptance and lasts exactly one cycle. Ready is low in the cycle after a write is accepted.
- R9: A read of a mapped logical page returns its data with the unmapped and error flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lpage | input | LA_W (4) | Logical page number |
| req_wdata | input | DATA_W (16) | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W (16) | Read data (all ones when unmapped) |
| rsp_ppage | output | PA_W (4) | Physical page programmed or read |
| rsp_unmapped | output | 1 | Read hit no mapping |
| rsp_error | output | 1 | Write refused |

## Verification
The assertions check the handshake on every cycle: one response for each acceptance, the busy cycle after a write, and all-ones data on unmapped reads. They also check that an erase only ever targets a block whose pages are all invalid, and that a newly opened block is fully erased when it is opened. Which block gets picked by erase count, out-of-place placement, data surviving in partly invalid blocks, and refusal once the array is exhausted depend on the full history of writes. Only the bench scenarios show these, by comparing against a reference model of the page states, the mapping and the wear counts.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

  typedef enum logic [1:0] {
    PG_ERASED  = 2'b00,
    PG_VALID   = 2'b01,
    PG_INVALID = 2'b10
  } page_state_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_MAINT = 1'b1
  } ctl_state_t;

endpackage

// File: rtl/ftl_flash_array.sv
module ftl_flash_array
  import ftl_pkg::*;
#(
  parameter int NB  = 4,
  parameter int PPB = 4,
  parameter int DW  = 16,
  localparam int NPG  = NB * PPB,
  localparam int PA_W = $clog2(NPG),
  localparam int BA_W = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_en,
  input  logic [PA_W-1:0] prog_addr,
  input  logic [DW-1:0]   prog_data,
  output logic            prog_err,
  input  logic            inv_en,
  input  logic [PA_W-1:0] inv_addr,
  input  logic            ers_en,
  input  logic [BA_W-1:0] ers_blk,
  input  logic [PA_W-1:0] rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [NB-1:0]   blk_all_erased,
  output logic [NB-1:0]   blk_all_invalid
);

  page_state_t state_q [NPG];
  page_state_t state_d [NPG];
  logic [DW-1:0] data_q [NPG];
  logic prog_ok;

  // a program lands only on an erased page
  assign prog_err = prog_en && (state_q[prog_addr] != PG_ERASED);
  assign prog_ok  = prog_en && !prog_err;
  assign rd_data  = data_q[rd_addr];

  always_comb begin
    for (int p = 0; p < NPG; p++) begin
      state_d[p] = state_q[p];
      if (prog_ok && prog_addr == PA_W'(p)) state_d[p] = PG_VALID;
      if (inv_en && inv_addr == PA_W'(p))   state_d[p] = PG_INVALID;
      if (ers_en && ers_blk == BA_W'(p / PPB)) state_d[p] = PG_ERASED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPG; p++) state_q[p] <= PG_ERASED;
    end else begin
      for (int p = 0; p < NPG; p++) state_q[p] <= state_d[p];
    end
  end

  always_ff @(posedge clk) begin
    if (prog_ok) data_q[prog_addr] <= prog_data;
  end

  for (genvar b = 0; b < NB; b++) begin : g_blk
    logic all_er, all_iv;
    always_comb begin
      all_er = 1'b1;
      all_iv = 1'b1;
      for (int k = 0; k < PPB; k++) begin
        all_er = all_er && (state_q[b*PPB+k] == PG_ERASED);
        all_iv = all_iv && (state_q[b*PPB+k] == PG_INVALID);
      end
    end
    assign blk_all_erased[b]  = all_er;
    assign blk_all_invalid[b] = all_iv;
  end

endmodule

// File: rtl/ftl_wear_table.sv
module ftl_wear_table #(
  parameter int NB     = 4,
  parameter int WEAR_W = 17,
  localparam int BA_W  = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ers_en,
  input  logic [BA_W-1:0] ers_blk,
  input  logic [NB-1:0]   cand,
  output logic            pick_valid,
  output logic [BA_W-1:0] pick_blk
);

  logic [WEAR_W-1:0] count_q [NB];
  logic [WEAR_W-1:0] best;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) count_q[i] <= '0;
    end else if (ers_en && count_q[ers_blk] != '1) begin
      count_q[ers_blk] <= count_q[ers_blk] + 1'b1;
    end
  end

  // strict less-than keeps the lowest index on equal counts
  always_comb begin
    pick_valid = 1'b0;
    pick_blk   = '0;
    best       = '0;
    for (int i = 0; i < NB; i++) begin
      if (cand[i] && (!pick_valid || count_q[i] < best)) begin
        pick_valid = 1'b1;
        pick_blk   = BA_W'(i);
        best       = count_q[i];
      end
    end
  end

endmodule

// File: rtl/ftl_map_table.sv
module ftl_map_table #(
  parameter int LP   = 12,
  parameter int PA_W = 4,
  localparam int LA_W = $clog2(LP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LA_W-1:0] lk_idx,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_phys,
  input  logic            upd_en,
  input  logic [LA_W-1:0] upd_idx,
  input  logic [PA_W-1:0] upd_phys
);

  logic            valid_q [LP];
  logic [PA_W-1:0] phys_q  [LP];
  logic            in_range;

  assign in_range = int'(lk_idx) < LP;
  assign lk_hit   = in_range && valid_q[lk_idx];
  assign lk_phys  = in_range ? phys_q[lk_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LP; i++) valid_q[i] <= 1'b0;
    end else if (upd_en) begin
      valid_q[upd_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) phys_q[upd_idx] <= upd_phys;
  end

endmodule

// File: rtl/ftl_mapper.sv
module ftl_mapper
  import ftl_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int LOGICAL_PAGES   = 12,
  parameter int DATA_W          = 16,
  parameter int WEAR_W          = 17,
  localparam int NPG  = NUM_BLOCKS * PAGES_PER_BLOCK,
  localparam int PA_W = $clog2(NPG),
  localparam int BA_W = $clog2(NUM_BLOCKS),
  localparam int PO_W = $clog2(PAGES_PER_BLOCK),
  localparam int LA_W = $clog2(LOGICAL_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [LA_W-1:0]   req_lpage,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [PA_W-1:0]   rsp_ppage,
  output logic              rsp_unmapped,
  output logic              rsp_error
);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  ctl_state_t     st_q, st_d;
  logic [BA_W-1:0] act_blk_q, act_blk_d;
  logic [PO_W-1:0] ptr_q, ptr_d;
  logic            full_q, full_d;

  logic              accept, prog_en, prog_err, prog_ok;
  logic [PA_W-1:0]   target;
  logic              lk_hit;
  logic [PA_W-1:0]   lk_phys;
  logic [DATA_W-1:0] rd_data;
  logic [NUM_BLOCKS-1:0] blk_all_erased, blk_all_invalid;
  logic              any_inv, ers_en, pick_valid, pick_take;
  logic [BA_W-1:0]   ers_blk, pick_blk;

  logic              rsp_valid_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [PA_W-1:0]   ppage_q, ppage_d;
  logic              unmapped_q, unmapped_d, error_q, error_d;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign target    = {act_blk_q, ptr_q};
  assign prog_en   = accept && req_write;
  assign prog_ok   = prog_en && !prog_err;

  ftl_map_table #(.LP(LOGICAL_PAGES), .PA_W(PA_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lk_idx   (req_lpage),
    .lk_hit   (lk_hit),
    .lk_phys  (lk_phys),
    .upd_en   (prog_ok),
    .upd_idx  (req_lpage),
    .upd_phys (target)
  );

  ftl_flash_array #(.NB(NUM_BLOCKS), .PPB(PAGES_PER_BLOCK), .DW(DATA_W)) u_flash (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .prog_en         (prog_en),
    .prog_addr       (target),
    .prog_data       (req_wdata),
    .prog_err        (prog_err),
    .inv_en          (prog_ok && lk_hit),
    .inv_addr        (lk_phys),
    .ers_en          (ers_en),
    .ers_blk         (ers_blk),
    .rd_addr         (lk_phys),
    .rd_data         (rd_data),
    .blk_all_erased  (blk_all_erased),
    .blk_all_invalid (blk_all_invalid)
  );

  ftl_wear_table #(.NB(NUM_BLOCKS), .WEAR_W(WEAR_W)) u_wear (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ers_en     (ers_en),
    .ers_blk    (ers_blk),
    .cand       (blk_all_erased),
    .pick_valid (pick_valid),
    .pick_blk   (pick_blk)
  );

  // maintenance: erase fully invalid blocks first, lowest index first
  always_comb begin
    ers_blk = '0;
    for (int b = NUM_BLOCKS - 1; b >= 0; b--) begin
      if (blk_all_invalid[b]) ers_blk = BA_W'(b);
    end
  end
  assign any_inv   = |blk_all_invalid;
  assign ers_en    = (st_q == ST_MAINT) && any_inv;
  assign pick_take = (st_q == ST_MAINT) && !any_inv && full_q && pick_valid;

  always_comb begin
    act_blk_d = act_blk_q;
    ptr_d     = ptr_q;
    full_d    = full_q;
    st_d      = st_q;
    if (prog_ok) begin
      if (ptr_q == PO_W'(PAGES_PER_BLOCK - 1)) full_d = 1'b1;
      else                                    ptr_d  = ptr_q + 1'b1;
    end
    if (pick_take) begin
      act_blk_d = pick_blk;
      ptr_d     = '0;
      full_d    = 1'b0;
    end
    case (st_q)
      ST_IDLE:  if (prog_en) st_d = ST_MAINT;
      ST_MAINT: if (!any_inv && !pick_take) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rdata_d    = '0;
    ppage_d    = target;
    unmapped_d = 1'b0;
    error_d    = 1'b0;
    if (req_write) begin
      error_d = prog_err;
    end else if (lk_hit) begin
      rdata_d = rd_data;
      ppage_d = lk_phys;
    end else begin
      rdata_d    = '1;
      ppage_d    = '0;
      unmapped_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q      <= ST_IDLE;
      act_blk_q <= '0;
      ptr_q     <= '0;
      full_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      act_blk_q <= act_blk_d;
      ptr_q     <= ptr_d;
      full_q    <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
      ppage_q     <= '0;
      unmapped_q  <= 1'b0;
      error_q     <= 1'b0;
    end else begin
      rsp_valid_q <= accept;
      if (accept) begin
        rdata_q    <= rdata_d;
        ppage_q    <= ppage_d;
        unmapped_q <= unmapped_d;
        error_q    <= error_d;
      end
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_rdata    = rdata_q;
  assign rsp_ppage    = ppage_q;
  assign rsp_unmapped = unmapped_q;
  assign rsp_error    = error_q;

endmodule

// File: rtl/ftl_mapper_checker.sv
module ftl_mapper_checker #(
  parameter int NB   = 4,
  parameter int BA_W = 2,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            req_write,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_unmapped,
  input logic            rsp_error,
  input logic [DW-1:0]   rsp_rdata,
  input logic            ers_en,
  input logic [BA_W-1:0] ers_blk,
  input logic [NB-1:0]   blk_all_invalid,
  input logic [NB-1:0]   blk_all_erased,
  input logic [BA_W-1:0] act_blk
);

  a_r8_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  a_r8_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(accept));

  a_r8_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> !req_ready);

  a_r2_unmapped_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_unmapped) |-> (rsp_rdata == '1));

  a_r5_error_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_error) |-> $past(accept && req_write));

  a_r6_erase_only_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    ers_en |-> blk_all_invalid[ers_blk]);

  a_r7_open_block_erased: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_blk) |-> blk_all_erased[act_blk]);

endmodule

bind ftl_mapper ftl_mapper_checker #(.NB(NUM_BLOCKS), .BA_W(BA_W), .DW(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .accept          (accept),
  .req_write       (req_write),
  .req_ready       (req_ready),
  .rsp_valid       (rsp_valid),
  .rsp_unmapped    (rsp_unmapped),
  .rsp_error       (rsp_error),
  .rsp_rdata       (rsp_rdata),
  .ers_en          (ers_en),
  .ers_blk         (ers_blk),
  .blk_all_invalid (blk_all_invalid),
  .blk_all_erased  (blk_all_erased),
  .act_blk         (act_blk_q)
);

// File: tb/ftl_mapper_test.sv
module ftl_mapper_test;
  localparam int NB = 4, PPB = 4, NPG = 16, LP = 12, DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_lpage = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_unmapped, rsp_error;
  logic [DW-1:0] rsp_rdata;
  logic [3:0] rsp_ppage;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ftl_mapper uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_lpage(req_lpage), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ppage(rsp_ppage),
    .rsp_unmapped(rsp_unmapped), .rsp_error(rsp_error)
  );

  // reference model: 0 erased, 1 valid, 2 invalid
  int m_state [NPG];
  logic [DW-1:0] m_data [NPG];
  bit m_mv [LP];
  int m_mp [LP];
  int m_wear [NB];
  int m_act, m_ptr;
  bit m_full;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit blk_is(int b, int s);
    for (int k = 0; k < PPB; k++) if (m_state[b*PPB+k] != s) return 0;
    return 1;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < NPG; p++) m_state[p] = 0;
    for (int l = 0; l < LP; l++) m_mv[l] = 0;
    for (int b = 0; b < NB; b++) m_wear[b] = 0;
    m_act = 0; m_ptr = 0; m_full = 0;
  endtask

  task automatic model_maint();
    bit moved;
    do begin
      moved = 0;
      for (int b = 0; b < NB && !moved; b++) begin
        if (blk_is(b, 2)) begin
          for (int k = 0; k < PPB; k++) m_state[b*PPB+k] = 0;
          m_wear[b]++;
          moved = 1;
        end
      end
      if (!moved && m_full) begin
        int best = -1;
        for (int b = 0; b < NB; b++)
          if (blk_is(b, 0) && (best < 0 || m_wear[b] < m_wear[best])) best = b;
        if (best >= 0) begin
          m_act = best; m_ptr = 0; m_full = 0; moved = 1;
        end
      end
    end while (moved);
  endtask

  task automatic do_reset();
    req_valid = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  // drive one request from a negedge; sample the response one negedge later
  task automatic issue(bit wr, int lp, logic [DW-1:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_lpage = 4'(lp); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 1'b1, "R8 response one cycle after accept", 32'(rsp_valid), 1);
  endtask

  task automatic do_write(int lp, logic [DW-1:0] d);
    int tgt = m_act * PPB + m_ptr;
    bit exp_err = (m_state[tgt] != 0);
    issue(1, lp, d);
    check(rsp_error == exp_err, exp_err ? "R5 refused program" : "R5 error clear",
          32'(rsp_error), 32'(exp_err));
    if (!exp_err)
      check(rsp_ppage == 4'(tgt), "R3 R7 physical placement", 32'(rsp_ppage), 32'(tgt));
    check(req_ready == 1'b0, "R8 busy after write", 32'(req_ready), 0);
    if (!exp_err) begin
      m_state[tgt] = 1; m_data[tgt] = d;
      if (m_mv[lp]) m_state[m_mp[lp]] = 2;
      m_mv[lp] = 1; m_mp[lp] = tgt;
      if (m_ptr == PPB - 1) m_full = 1; else m_ptr++;
    end
    model_maint();
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8 single-cycle response", 32'(rsp_valid), 0);
  endtask

  task automatic do_read(int lp, string tag);
    bit exp_unm = !m_mv[lp];
    logic [DW-1:0] exp_d = exp_unm ? '1 : m_data[m_mp[lp]];
    issue(0, lp, '0);
    check(rsp_unmapped == exp_unm, {tag, " unmapped flag"}, 32'(rsp_unmapped), 32'(exp_unm));
    check(rsp_rdata == exp_d, {tag, " read data"}, 32'(rsp_rdata), 32'(exp_d));
    check(rsp_error == 1'b0, {tag, " no error on read"}, 32'(rsp_error), 0);
    @(negedge clk);
  endtask

  task automatic expect_page(int lp, logic [DW-1:0] d, int page, string tag);
    issue(1, lp, d);
    check(rsp_ppage == 4'(page), tag, 32'(rsp_ppage), 32'(page));
    check(rsp_error == 1'b0, tag, 32'(rsp_error), 0);
    m_state[m_act*PPB+m_ptr] = 1; m_data[m_act*PPB+m_ptr] = d;
    if (m_mv[lp]) m_state[m_mp[lp]] = 2;
    m_mv[lp] = 1; m_mp[lp] = m_act*PPB+m_ptr;
    if (m_ptr == PPB - 1) m_full = 1; else m_ptr++;
    model_maint();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7011));
    do_reset();
    // R1: reset state
    check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);
    do_read(5, "R1 R2 unmapped after reset");
    do_read(0, "R2");

    // R3, R4, R6, R7: directed placement and wear choice
    for (int l = 0; l < 4; l++) expect_page(l, 16'h1000 + 16'(l), l, "R3 ascending pages in block 0");
    for (int l = 0; l < 4; l++) expect_page(l, 16'h2000 + 16'(l), 4 + l, "R4 out of place into block 1");
    do_read(2, "R4 newest copy");
    expect_page(0, 16'h3000, 8, "R7 least-worn block 2 over erased block 0");
    for (int l = 1; l < 4; l++) expect_page(l, 16'h3000 + 16'(l), 8 + l, "R3 block 2");
    expect_page(0, 16'h4000, 12, "R7 least-worn block 3");
    for (int l = 1; l < 4; l++) expect_page(l, 16'h4000 + 16'(l), 12 + l, "R3 block 3");
    expect_page(4, 16'h5000, 0, "R6 R7 tie on wear picks lowest index");
    do_read(4, "R9 mapped read");
    do_read(3, "R9");

    // R5, R6: exhaustion with partly valid blocks
    do_reset();
    do_read(0, "R1 map cleared by reset");
    for (int l = 0; l < LP; l++) do_write(l, 16'hA000 + 16'(l));
    do_write(0, 16'hB000);
    do_write(4, 16'hB004);
    do_write(8, 16'hB008);
    do_write(1, 16'hB001);
    do_write(2, 16'hC002);
    check(rsp_error == 1'b1, "R5 write refused when no erased page", 32'(rsp_error), 1);
    do_read(2, "R5 data unchanged after refusal");
    do_read(5, "R6 valid data in partly invalid block");
    do_read(4, "R4 newest copy");

    // random: hot writes on two pages, reads anywhere
    do_reset();
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 9) < 6) do_write($urandom_range(0, 1), 16'($urandom));
      else do_read($urandom_range(0, LP - 1), "R9 R2 R6 random");
    end
    // random: writes over the whole logical space until exhaustion
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 1) == 0) do_write($urandom_range(0, LP - 1), 16'($urandom));
      else do_read($urandom_range(0, LP - 1), "R4 R5 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule